// File: doc/BRIEF.md
# Type 0 Configuration Access Claim Decoder

This block sits on the target side of a parallel PCI or PCI-X bus and watches each address phase. When the device is selected, the command is a configuration read or write, and the access is Type 0, it claims the cycle. It then latches the register index and function number and, in the following data phase, applies the active-low byte enables to a small backing register file. Each function has its own storage. The block also flags whether the host must complete the claimed cycle as a delayed transaction (conventional mode) or as a split transaction (either PCI-X mode).

The decoder knows three bus modes. In the extended PCI-X mode, four upper address bits widen the register index to 1024 DWORDs. Any DWORD outside the implemented window reads as zero and drops writes. This covers the header at byte offset 100h, which therefore reports that no extended capabilities exist. A multi-function control bit decides whether function 1 answers.

Top module: `cfg_claim_decoder`

## Requirements
- R1: The block claims a cycle when, at the address phase (the first clock with `frame_n` low after a clock with it high), `idsel` is 1, `cbe_n` is 4'b1010 (read) or 4'b1011 (write), `ad[1:0]` is 2'b00, and the function is accepted. A claim drives `devsel_n` low for exactly the one following clock, which is the data phase.
- R2: An address phase with `ad[1:0]` not 2'b00 (for example Type 1), with `idsel` low, or with any other command code produces no claim and leaves the storage unchanged.
- R3: The function number is `ad[10:8]`. Function 0 is always accepted. Function 1 is accepted only when `multi_fn_en` is 1. Functions 2 to 7 are never accepted. Functions 0 and 1 have separate storage.
- R4: `reg_index[5:0]` is `ad[7:2]`. In mode 2'b1x (extended PCI-X), `reg_index[9:6]` is `ad[27:24]`. In modes 2'b00 and 2'b01, `reg_index[9:6]` is forced to zero and `ad[27:24]` is ignored.
- R5: In a claimed data phase, `byte_lanes` equals `~cbe_n`. A write updates only the enabled bytes, with byte n taken from `ad[8n+7:8n]`. Read data carries stored bytes on enabled lanes and zero on the others. Outside a claimed data phase, `byte_lanes` and `rd_data` are zero.
- R6: DWORD indices at or above IMPL_DW (default 16) read as zero and discard writes. In mode 2'b1x this includes index 64 (byte offset 100h).
- R7: `split_txn` is 1 during a claimed data phase latched in mode 2'b01 or 2'b1x. It is 0 for a claim latched in mode 2'b00, and 0 whenever `devsel_n` is high.
- R8: After reset, `devsel_n` is 1, `byte_lanes`, `rd_data` and `split_txn` are 0, and every stored DWORD reads as zero.
- R9: `reg_index` and `func_num` are latched at the address phase. They hold through the data phase even though `ad` then carries data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad | input | 32 | Multiplexed address / write data |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| idsel | input | 1 | Device select for configuration cycles |
| frame_n | input | 1 | Active-low cycle frame; its falling edge marks the address phase |
| mode | input | 2 | 00 conventional, 01 PCI-X, 1x extended PCI-X |
| multi_fn_en | input | 1 | Allows function 1 to answer |
| devsel_n | output | 1 | Active-low claim during the data phase |
| split_txn | output | 1 | Claimed cycle completes as split (1) or delayed (0) |
| reg_index | output | 10 | Latched DWORD index |
| func_num | output | 3 | Latched function number |
| byte_lanes | output | 4 | Active-high byte lanes of the claimed data phase |
| rd_data | output | 32 | Read data of a claimed read |

## Verification
The bench sends Type 1 writes, writes to function numbers above 1, function 1 writes while multi-function is off, and writes with a non-configuration command. It then reads the same DWORD back through a legal access, so a decoder that claimed any of these would return corrupted data. A PCI-X write with nonzero upper bits must land on the lower DWORD and be visible from conventional mode. An extended-mode write to offset 100h must read back as zero, which a design that stored it or aliased it onto DWORD 0 would fail. Partial byte enables on writes and reads expose any lane inversion, and a mode bug shows up as a wrong completion flag.

// File: rtl/cfg_claim_decoder.sv
module cfg_claim_decoder #(
  parameter int IMPL_DW = 16,
  parameter int NFUNC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe_n,
  input  logic        idsel,
  input  logic        frame_n,
  input  logic [1:0]  mode,
  input  logic        multi_fn_en,
  output logic        devsel_n,
  output logic        split_txn,
  output logic [9:0]  reg_index,
  output logic [2:0]  func_num,
  output logic [3:0]  byte_lanes,
  output logic [31:0] rd_data
);
  localparam int IW = $clog2(IMPL_DW);
  localparam logic [3:0] CMD_RD = 4'b1010;
  localparam logic [3:0] CMD_WR = 4'b1011;

  logic frame_q, claim_q, wr_q, split_q, dphase_q;
  logic [9:0] idx_q;
  logic [2:0] fn_q;
  logic [31:0] mem [NFUNC][IMPL_DW];

  wire addr_ph  = !frame_n && frame_q;
  wire is_cfg   = (cbe_n == CMD_RD) || (cbe_n == CMD_WR);
  wire fn_ok    = (ad[10:8] == 3'd0) || (ad[10:8] == 3'd1 && multi_fn_en);
  wire hit      = idsel && is_cfg && (ad[1:0] == 2'b00) && fn_ok;
  wire active   = dphase_q && claim_q;
  wire in_range = idx_q < 10'(IMPL_DW);
  wire [IW-1:0] slot = idx_q[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= 1'b1;
      claim_q  <= 1'b0;
      wr_q     <= 1'b0;
      split_q  <= 1'b0;
      dphase_q <= 1'b0;
      idx_q    <= '0;
      fn_q     <= '0;
    end else begin
      frame_q  <= frame_n;
      dphase_q <= addr_ph;
      if (addr_ph) begin
        claim_q <= hit;
        wr_q    <= cbe_n[0];
        split_q <= (mode != 2'b00);
        idx_q   <= {(mode[1] ? ad[27:24] : 4'd0), ad[7:2]};
        fn_q    <= ad[10:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NFUNC; f++)
        for (int i = 0; i < IMPL_DW; i++)
          mem[f][i] <= '0;
    end else if (active && wr_q && in_range) begin
      for (int b = 0; b < 4; b++)
        if (!cbe_n[b]) mem[fn_q[0]][slot][8*b +: 8] <= ad[8*b +: 8];
    end
  end

  wire [31:0] lane_mask = {{8{byte_lanes[3]}}, {8{byte_lanes[2]}},
                           {8{byte_lanes[1]}}, {8{byte_lanes[0]}}};

  assign devsel_n   = !active;
  assign split_txn  = active && split_q;
  assign reg_index  = idx_q;
  assign func_num   = fn_q;
  assign byte_lanes = active ? ~cbe_n : 4'b0000;
  assign rd_data    = (active && !wr_q && in_range) ? (mem[fn_q[0]][slot] & lane_mask) : 32'd0;
endmodule

module cfg_claim_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ad,
  input logic [3:0]  cbe_n,
  input logic        idsel,
  input logic        frame_n,
  input logic [1:0]  mode,
  input logic        multi_fn_en,
  input logic        devsel_n,
  input logic        split_txn,
  input logic [9:0]  reg_index,
  input logic [3:0]  byte_lanes,
  input logic [31:0] rd_data
);
  logic fr_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fr_q <= 1'b1; else fr_q <= frame_n;
  wire aph = !frame_n && fr_q;

  // R1
  claim_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel_n |=> devsel_n);
  // R2
  type1_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aph && ad[1:0] != 2'b00) |=> devsel_n);
  // R2
  no_idsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aph && !idsel) |=> devsel_n);
  // R3
  high_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aph && (ad[10:9] != 2'b00 || (ad[8] && !multi_fn_en))) |=> devsel_n);
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aph && !mode[1]) |=> reg_index[9:6] == 4'd0);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    devsel_n |-> (byte_lanes == 4'd0 && rd_data == 32'd0 && !split_txn));
  // R7
  split_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aph |=> (devsel_n || split_txn == ($past(mode) != 2'b00)));
endmodule

bind cfg_claim_decoder cfg_claim_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .idsel(idsel),
  .frame_n(frame_n), .mode(mode), .multi_fn_en(multi_fn_en),
  .devsel_n(devsel_n), .split_txn(split_txn), .reg_index(reg_index),
  .byte_lanes(byte_lanes), .rd_data(rd_data)
);

// File: tb/cfg_claim_decoder_test.sv
module cfg_claim_decoder_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] ad = 0;
  logic [3:0] cbe_n = 4'hF;
  logic idsel = 0, frame_n = 1, multi_fn_en = 0;
  logic [1:0] mode = 0;
  logic devsel_n, split_txn;
  logic [9:0] reg_index;
  logic [2:0] func_num;
  logic [3:0] byte_lanes;
  logic [31:0] rd_data;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_claim_decoder uut (.*);

  typedef struct {
    bit claim; bit split; logic [9:0] idx; logic [2:0] fn;
    logic [3:0] lanes; logic [31:0] rd; string tag;
  } exp_t;
  exp_t q[$];
  logic [31:0] model [2][16];
  event dp_ev;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input string tag, input logic [1:0] md, input bit mfe, input bit sel,
                     input logic [3:0] cmd, input logic [2:0] fn, input logic [3:0] up,
                     input logic [5:0] lo, input logic [1:0] low2, input logic [3:0] be,
                     input logic [31:0] data);
    exp_t e;
    bit claim;
    logic [9:0] idx;
    logic [31:0] m;
    claim = sel && (cmd == 4'hA || cmd == 4'hB) && low2 == 0 && (fn == 0 || (fn == 1 && mfe));
    idx = md[1] ? {up, lo} : {4'd0, lo};
    m = {{8{~be[3]}}, {8{~be[2]}}, {8{~be[1]}}, {8{~be[0]}}};
    e.claim = claim; e.split = claim && md != 0; e.idx = idx; e.fn = fn;
    e.lanes = claim ? ~be : 4'd0; e.tag = tag;
    e.rd = (claim && cmd == 4'hA && idx < 16) ? (model[fn[0]][idx[3:0]] & m) : 32'd0;
    if (claim && cmd == 4'hB && idx < 16)
      model[fn[0]][idx[3:0]] = (model[fn[0]][idx[3:0]] & ~m) | (data & m);
    q.push_back(e);
    @(negedge clk);
    mode = md; multi_fn_en = mfe; idsel = sel; cbe_n = cmd; frame_n = 0;
    ad = {4'hC, up, 13'h0, fn, lo, low2};
    @(negedge clk);
    frame_n = 1; idsel = 0; cbe_n = be; ad = data;
    #2 -> dp_ev;
  endtask

  initial begin
    forever begin
      exp_t e;
      @(dp_ev);
      e = q.pop_front();
      chk(e.tag, "devsel_n", 32'(devsel_n), 32'(!e.claim));
      chk(e.tag, "split_txn", 32'(split_txn), 32'(e.split));
      chk(e.tag, "byte_lanes", 32'(byte_lanes), 32'(e.lanes));
      chk(e.tag, "rd_data", rd_data, e.rd);
      if (e.claim) begin
        chk(e.tag, "reg_index (R4/R9)", 32'(reg_index), 32'(e.idx));
        chk(e.tag, "func_num (R3/R9)", 32'(func_num), 32'(e.fn));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 2; f++) for (int i = 0; i < 16; i++) model[f][i] = 0;
    #3;
    // R8 reset state
    chk("R8", "devsel_n", 32'(devsel_n), 1);
    chk("R8", "rd_data", rd_data, 0);
    chk("R8", "byte_lanes", 32'(byte_lanes), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    cfg("R8", 0, 0, 1, 4'hA, 0, 0, 6'd3, 0, 4'h0, 32'h0);
    // R1 / R5 full write then read
    cfg("R1", 0, 0, 1, 4'hB, 0, 0, 6'd3, 0, 4'h0, 32'hA1B2C3D4);
    cfg("R1", 0, 0, 1, 4'hA, 0, 0, 6'd3, 0, 4'h0, 32'h0);
    // R5 partial lanes
    cfg("R5", 2'b01, 0, 1, 4'hB, 0, 0, 6'd3, 0, 4'b1010, 32'h11223344);
    cfg("R5", 0, 0, 1, 4'hA, 0, 0, 6'd3, 0, 4'b0110, 32'h0);
    cfg("R5", 0, 0, 1, 4'hA, 0, 0, 6'd3, 0, 4'h0, 32'h0);
    // R2 Type 1, no idsel, wrong command
    cfg("R2", 0, 1, 1, 4'hB, 0, 0, 6'd3, 2'b01, 4'h0, 32'hDEADBEEF);
    cfg("R2", 0, 1, 0, 4'hB, 0, 0, 6'd3, 0, 4'h0, 32'hDEADBEEF);
    cfg("R2", 0, 1, 1, 4'h7, 0, 0, 6'd3, 0, 4'h0, 32'hDEADBEEF);
    cfg("R2", 0, 1, 1, 4'hA, 0, 0, 6'd3, 0, 4'h0, 32'h0);
    // R3 function acceptance
    cfg("R3", 0, 0, 1, 4'hB, 1, 0, 6'd3, 0, 4'h0, 32'h55555555);
    cfg("R3", 0, 1, 1, 4'hB, 2, 0, 6'd3, 0, 4'h0, 32'h66666666);
    cfg("R3", 0, 1, 1, 4'hA, 1, 0, 6'd3, 0, 4'h0, 32'h0);
    cfg("R3", 0, 1, 1, 4'hB, 1, 0, 6'd3, 0, 4'h0, 32'h77778888);
    cfg("R3", 0, 1, 1, 4'hA, 1, 0, 6'd3, 0, 4'h0, 32'h0);
    cfg("R3", 0, 1, 1, 4'hA, 0, 0, 6'd3, 0, 4'h0, 32'h0);
    // R4 upper bits ignored outside extended mode, used in it
    cfg("R4", 2'b01, 0, 1, 4'hB, 0, 4'h5, 6'd7, 0, 4'h0, 32'hCAFEF00D);
    cfg("R4", 0, 0, 1, 4'hA, 0, 4'h9, 6'd7, 0, 4'h0, 32'h0);
    cfg("R4", 2'b10, 0, 1, 4'hA, 0, 4'h3, 6'd7, 0, 4'h0, 32'h0);
    // R6 extended range, offset 100h
    cfg("R6", 2'b10, 0, 1, 4'hB, 0, 4'h1, 6'd0, 0, 4'h0, 32'h12345678);
    cfg("R6", 2'b10, 0, 1, 4'hA, 0, 4'h1, 6'd0, 0, 4'h0, 32'h0);
    cfg("R6", 2'b11, 0, 1, 4'hB, 0, 4'h0, 6'd20, 0, 4'h0, 32'h9ABCDEF0);
    cfg("R6", 2'b11, 0, 1, 4'hA, 0, 4'h0, 6'd20, 0, 4'h0, 32'h0);
    cfg("R6", 0, 0, 1, 4'hA, 0, 0, 6'd0, 0, 4'h0, 32'h0);
    // R7 completion kind per mode
    cfg("R7", 2'b00, 0, 1, 4'hA, 0, 0, 6'd7, 0, 4'h0, 32'h0);
    cfg("R7", 2'b01, 0, 1, 4'hA, 0, 0, 6'd7, 0, 4'h0, 32'h0);
    cfg("R7", 2'b10, 0, 1, 4'hA, 0, 0, 6'd7, 0, 4'h0, 32'h0);
    // R9 fields held while ad carries data
    cfg("R9", 2'b10, 1, 1, 4'hB, 1, 4'h0, 6'd9, 0, 4'h0, 32'hFFFFFFFF);
    cfg("R9", 2'b10, 1, 1, 4'hA, 1, 4'h0, 6'd9, 0, 4'h0, 32'h00000000);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule